// File: doc/BRIEF.md
# Two-Bit Burst Address Generator

This block is the address front end of a synchronous burst memory. A new external address is captured whenever either of two address strobes is raised: one driven from the processor side, one from the memory-controller side. Once captured, the two least significant address bits step through a four-word burst. They move forward only on cycles where the advance input is high. The upper address bits stay fixed until the next load.

A mode input chooses the order of the low bits. In linear order they count upward modulo four from the loaded value. In interleaved order the k-th word of the burst uses the loaded low bits XOR k. Interleaved order is selected when the mode input is low. Bursting is optional: a strobe on every cycle captures a fresh address each cycle with no gap. A status output shows which strobe started the current burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, the next rising edge clears `addr_out` to zero and `src_ctl` to 0.
- R2: When `stb_cpu` or `stb_ctl` is high at a rising edge, `addr_out` equals the `addr_in` value sampled at that edge, from the following cycle.
- R3: When both strobes are high in the same cycle, the processor strobe wins and `src_ctl` reads 0 afterwards. After a load from `stb_ctl` alone, `src_ctl` reads 1.
- R4: A strobe overrides `adv` in the same cycle: the address is loaded and the burst index restarts at 0.
- R5: With `order_lin` = 1, each advance makes the low two bits equal to the loaded low bits plus k modulo 4, where k is the number of advances since the load (for example 1,2,3,0).
- R6: With `order_lin` = 0, each advance makes the low two bits equal to the loaded low bits XOR k (for example 1,0,3,2).
- R7: The burst is four words long. The fourth advance after a load returns the low bits to the loaded value, and counting continues in the same order.
- R8: An advance without a strobe leaves `addr_out` bits above bit 1 unchanged.
- R9: In a cycle with no strobe and no advance, `addr_out` and `src_ctl` keep their values.
- R10: A strobe on consecutive cycles loads each new address in turn, with no idle cycle between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_cpu | input | 1 | Processor-side address strobe (higher priority) |
| stb_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Advance the burst by one word |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | External address captured on a strobe |
| addr_out | output | ADDR_W | Current address presented to the array |
| src_ctl | output | 1 | 1 when the last load came from `stb_ctl` alone |

## Verification
Bursts are started at several low-bit offsets in both orders. Walking four or more advances per burst separates an adder from an XOR and shows whether the counter wraps or runs into the upper bits. Advances with idle cycles between them show that the address moves only on `adv`. Strobes that coincide with each other or with `adv` expose the priority and the override. Strobes on every cycle, with differing upper bits, show that no load is lost.

// File: rtl/burst_addr_gen_pkg.sv
// Package: shared types and the burst-order function for the burst address generator.
// Assumes burst index and low-address widths are equal.
package burst_addr_gen_pkg;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_CTL = 1'b1
    } load_src_e;

    // Low bits for a given burst position: linear add or interleaved XOR.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] pos,
                                             input logic       linear);
        return linear ? (start + pos) : (start ^ pos);
    endfunction

endpackage

// File: rtl/agen_strobe_arb.sv
// Strobe arbiter: combines the two address strobes into one load request
// and reports which strobe won. The processor strobe has priority.
// Assumes both strobes are synchronous to the same clock.
module agen_strobe_arb
    import burst_addr_gen_pkg::*;
(
    input  logic      stb_cpu,
    input  logic      stb_ctl,
    output logic      load,
    output load_src_e src
);

    // Resolve the load request and its source.
    always_comb begin
        load = stb_cpu | stb_ctl;
        src  = stb_cpu ? SRC_CPU : (stb_ctl ? SRC_CTL : SRC_CPU);
    end

endmodule

// File: rtl/agen_burst_state.sv
// Burst state: holds the loaded start low bits and the burst index.
// Produces next-state values so the address register can follow in the same edge.
// Assumes load has priority over advance.
module agen_burst_state #(
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [BB-1:0] load_low,
    output logic [BB-1:0] start_d,
    output logic [BB-1:0] idx_d
);

    logic [BB-1:0] start_q;
    logic [BB-1:0] idx_q;

    // Next start and index: a load restarts the burst, an advance steps it modulo 2**BB.
    always_comb begin
        start_d = start_q;
        idx_d   = idx_q;
        if (load) begin
            start_d = load_low;
            idx_d   = '0;
        end else if (adv) begin
            idx_d = idx_q + 1'b1;
        end
    end

    // Register the burst state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            idx_q   <= '0;
        end else begin
            start_q <= start_d;
            idx_q   <= idx_d;
        end
    end

endmodule

// File: rtl/agen_order_map.sv
// Order map: turns a start value and burst index into the low address bits.
// The ORDER parameter fixes one order at build time, or keeps both selectable.
// Assumes BB is 2, which is the width the package function handles.
module agen_order_map #(
    parameter int BB    = 2,
    parameter int ORDER = 2   // 0 interleaved only, 1 linear only, 2 selectable
) (
    input  logic [BB-1:0] start,
    input  logic [BB-1:0] idx,
    input  logic          linear,
    output logic [BB-1:0] low
);

    import burst_addr_gen_pkg::*;

    generate
        if (ORDER == 0) begin : g_ilv
            // Interleaved only.
            always_comb low = burst_low(start, idx, 1'b0);
        end else if (ORDER == 1) begin : g_lin
            // Linear only.
            always_comb low = burst_low(start, idx, 1'b1);
        end else begin : g_sel
            // Order chosen at run time by the mode input.
            always_comb low = burst_low(start, idx, linear);
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator top: loads an external address on either strobe,
// then steps the two low bits in linear or interleaved order on each advance.
// Upper bits are held for the whole burst. Registered output, synchronous active-low reset.
// Assumes ADDR_W > BURST_BITS.
module burst_addr_gen
    import burst_addr_gen_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_cpu,
    input  logic              stb_ctl,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              src_ctl
);

    localparam int HI_W = ADDR_W - BURST_BITS;

    logic                  load;
    load_src_e             src;
    logic [BURST_BITS-1:0] start_d;
    logic [BURST_BITS-1:0] idx_d;
    logic [BURST_BITS-1:0] low_d;
    logic [HI_W-1:0]       hi_q;
    logic [BURST_BITS-1:0] low_q;
    load_src_e             src_q;

    agen_strobe_arb u_arb (
        .stb_cpu (stb_cpu),
        .stb_ctl (stb_ctl),
        .load    (load),
        .src     (src)
    );

    agen_burst_state #(.BB(BURST_BITS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .load_low (addr_in[BURST_BITS-1:0]),
        .start_d  (start_d),
        .idx_d    (idx_d)
    );

    agen_order_map #(.BB(BURST_BITS), .ORDER(2)) u_map (
        .start  (start_d),
        .idx    (idx_d),
        .linear (order_lin),
        .low    (low_d)
    );

    // Register the upper bits and the load source; both change only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            src_q <= SRC_CPU;
        end else if (load) begin
            hi_q  <= addr_in[ADDR_W-1:BURST_BITS];
            src_q <= src;
        end
    end

    // Register the low bits from the order map.
    always_ff @(posedge clk) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assign addr_out = {hi_q, low_q};
    assign src_ctl  = (src_q == SRC_CTL);

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen: port-level temporal properties, bound into the top.
module burst_addr_gen_chk #(
    parameter int ADDR_W     = 20,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stb_cpu,
    input logic              stb_ctl,
    input logic              adv,
    input logic              order_lin,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              src_ctl
);

    // R2, R10: any strobe loads addr_in.
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_cpu || stb_ctl) |=> addr_out == $past(addr_in));

    // R3: the processor strobe wins, alone or together with the other strobe.
    a_r3_cpu_priority: assert property (@(posedge clk) disable iff (!rst_n)
        stb_cpu |=> !src_ctl);

    // R3: the controller strobe alone sets the source flag.
    a_r3_ctl_source: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_ctl && !stb_cpu) |=> src_ctl);

    // R8: an advance keeps the upper bits.
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !stb_cpu && !stb_ctl)
        |=> addr_out[ADDR_W-1:BURST_BITS] == $past(addr_out[ADDR_W-1:BURST_BITS]));

    // R8: an advance always changes the low bits.
    a_r8_low_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !stb_cpu && !stb_ctl)
        |=> addr_out[BURST_BITS-1:0] != $past(addr_out[BURST_BITS-1:0]));

    // R9: no strobe and no advance holds the address and the source.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !stb_cpu && !stb_ctl && $stable(order_lin))
        |=> ($stable(addr_out) && $stable(src_ctl)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_cpu   (stb_cpu),
    .stb_ctl   (stb_ctl),
    .adv       (adv),
    .order_lin (order_lin),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .src_ctl   (src_ctl)
);

// File: tb/burst_addr_gen_tb_top.sv
// Scoreboard bench: drive() updates a reference model and queues the expected
// result; the monitor compares it 1 ns after the following rising edge.
module burst_addr_gen_tb_top;

    localparam int AW = 20;

    typedef struct {
        logic [AW-1:0] addr;
        logic          src;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stb_cpu = 1'b0;
    logic          stb_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          order_lin = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          src_ctl;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;

    // Reference model state.
    logic [AW-3:0] m_hi = '0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_k = '0;
    logic          m_src = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_cpu   (stb_cpu),
        .stb_ctl   (stb_ctl),
        .adv       (adv),
        .order_lin (order_lin),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .src_ctl   (src_ctl)
    );

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Drive one cycle of stimulus and queue the expected result.
    task automatic drive(input logic c, input logic t, input logic a,
                         input logic lin, input logic [AW-1:0] ad, input string req);
        exp_t e;
        @(negedge clk);
        stb_cpu = c; stb_ctl = t; adv = a; order_lin = lin; addr_in = ad;
        if (c || t) begin
            m_hi = ad[AW-1:2]; m_start = ad[1:0]; m_k = 2'd0; m_src = !c;
        end else if (a) begin
            m_k = m_k + 2'd1;
        end
        e.addr = {m_hi, lin ? (m_start + m_k) : (m_start ^ m_k)};
        e.src  = m_src;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    // Monitor: compare outputs with the queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (addr_out !== e.addr || src_ctl !== e.src) begin
                    n_fail++;
                    $display("FAIL %s: addr=%h src=%b expected addr=%h src=%b",
                             e.req, addr_out, src_ctl, e.addr, e.src);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        n_checks++;
        if (addr_out !== '0 || src_ctl !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: addr=%h src=%b expected addr=0 src=0", addr_out, src_ctl);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R10: back-to-back loads, different upper bits.
        drive(1, 0, 0, 0, 20'h12345, "R10");
        drive(1, 0, 0, 0, 20'hABCDE, "R10");
        drive(0, 1, 0, 0, 20'h0F0F2, "R10");
        // R2: controller strobe load, then hold (R9).
        drive(0, 1, 0, 0, 20'h55551, "R2");
        drive(0, 0, 0, 0, 20'hFFFFF, "R9");
        // R3: both strobes, processor wins.
        drive(1, 1, 0, 0, 20'h33333, "R3");
        // R4: strobe with advance loads, index restarts.
        drive(0, 1, 1, 0, 20'h44446, "R4");
        drive(0, 0, 1, 0, 20'h0, "R4");

        // R6, R7: interleaved from low=1, five advances with gaps.
        drive(1, 0, 0, 0, 20'h80001, "R6");
        for (int i = 0; i < 5; i++) begin
            drive(0, 0, 1, 0, 20'h0, (i == 3) ? "R7" : "R6");
            drive(0, 0, 0, 0, 20'h0, "R9");
        end
        // R6: interleaved from low=2.
        drive(1, 0, 0, 0, 20'h7FFFE, "R6");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 20'h0, "R6");

        // R5, R7: linear from low=1, and from low=3 (top word, wrap without carry, R8).
        drive(0, 1, 0, 1, 20'h24681, "R5");
        for (int i = 0; i < 5; i++) drive(0, 0, 1, 1, 20'h0, (i == 3) ? "R7" : "R5");
        drive(1, 0, 0, 1, 20'h3FFFF, "R8");
        for (int i = 0; i < 4; i++) drive(0, 0, 1, 1, 20'h0, "R8");
        drive(0, 0, 0, 1, 20'h0, "R9");

        // Mid-burst reload in linear mode (R4).
        drive(1, 0, 1, 1, 20'h10002, "R4");
        drive(0, 0, 1, 1, 20'h0, "R5");

        // Synchronous reset after activity (R1).
        @(negedge clk);
        stb_cpu = 0; stb_ctl = 0; adv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        n_checks++;
        if (addr_out !== '0 || src_ctl !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: addr=%h src=%b expected addr=0 src=0", addr_out, src_ctl);
        end

        repeat (2) @(negedge clk);
        report();
        $finish;
    end

endmodule